// File: doc/BRIEF.md
# Supply-Gated Static Memory

This block is a 2048 x 8 static memory with a gate in front of it that watches two supply-status flags. With good supply it behaves like a plain asynchronous-style SRAM: active-low chip select, output enable and write enable, an 11-bit address, a byte-wide data input and a byte-wide data output with its own drive-enable flag. Reads ripple through combinationally in the same cycle. Writes land on the clock edge. Every access takes one cycle and there is no limit on the number of writes.

Two inputs stand in for the analog comparators. `sup_ok` is high while supply is above the deselect threshold. `sup_sw` is high while supply is above the battery switchover level. When `sup_ok` drops, the three control inputs are ignored at once: nothing is driven and nothing is written. The block reports `deselected` or, when `sup_sw` is also low, `battery`. When `sup_ok` returns, a recovery window of `RECOV_CYC` clock cycles must pass before accesses are honoured again. The window stands for the 2 ms wake-up time and restarts if supply dips during it. The data interface is a plain single-cycle strobe and has no back-pressure. The memory accepts an access in any cycle it is enabled, so no valid/ready pair is needed.

Top module: `pgs_top`

## Requirements
- R1: The array holds 2^11 bytes. Every address in 0..2047 can be written and read back independently.
- R2: With `ce_n` high, `rd_oe` stays 0, `rd_data` is 0, and no write happens, whatever `we_n` and `oe_n` are.
- R3: In normal state, with `ce_n`=0 and `we_n`=0, `wr_data` is stored at `addr` on the clock edge, whatever `oe_n` is. `rd_oe` stays 0 during the write.
- R4: In normal state, with `ce_n`=0, `we_n`=1 and `oe_n`=0, `rd_oe` is 1 and `rd_data` equals the byte stored at `addr`, in the same cycle. Whenever `rd_oe` is 0, `rd_data` is 0.
- R5: With `ce_n`=0, `we_n`=1 and `oe_n`=1, `rd_oe` stays 0 and memory does not change.
- R6: While `sup_ok` is 0, `rd_oe` is 0 in that same cycle and no write occurs. After the next edge, `status` is 1 (deselected) if `sup_sw` is 1.
- R7: While both `sup_ok` and `sup_sw` are 0, `status` is 3 (battery) from the next edge on, and the stored contents are kept unchanged.
- R8: After `sup_ok` returns to 1, `status` is 2 (recovering) for exactly `RECOV_CYC` cycles and then 0 (normal). Accesses attempted while recovering are ignored.
- R9: If `sup_ok` falls during recovery, the count is abandoned. The next return of supply starts a full `RECOV_CYC` window.
- R10: While `rst_n` is low, `status` is 1. Reset clears only the gating state and the counter. Memory contents survive reset, and the block goes through a full recovery window after reset is released.
- R11: Writes in consecutive cycles to different addresses all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the gating state |
| sup_ok | input | 1 | Supply above deselect threshold |
| sup_sw | input | 1 | Supply above battery switchover level |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not driven |
| rd_oe | output | 1 | Read data drive enable |
| status | output | 2 | 0 normal, 1 deselected, 2 recovering, 3 battery |

## Verification
The assertions check the following on every cycle:
- A high chip enable, low supply or any non-normal state never coexists with a write strobe or a driven output.
- A write and a driven output never occur together.
- Supply returning always leads to the recovering state.
- The recovery counter stays within its window.

The bench's scenarios are needed for the rest:
- The data path itself, through a full write-then-read sweep of all 2048 addresses.
- The exact length of the recovery window and its restart after a dip.
- Contents surviving battery mode and reset.

## Verification Signals
(none beyond the ports above)

// File: rtl/pgs_pkg.sv
`timescale 1ns/1ps
package pgs_pkg;
  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_DESEL   = 2'd1,
    PS_RECOVER = 2'd2,
    PS_BATTERY = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pgs_supervisor.sv
`timescale 1ns/1ps
module pgs_supervisor
  import pgs_pkg::*;
#(
  parameter int RECOV_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok_i,
  input  logic       sup_sw_i,
  output pwr_state_e state_o
);
  localparam int CNT_W = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOV_CYC - 1);

  pwr_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!sup_ok_i) begin
      state_d = sup_sw_i ? PS_DESEL : PS_BATTERY;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PS_DESEL, PS_BATTERY: begin
          state_d = PS_RECOVER;
          cnt_d   = '0;
        end
        PS_RECOVER: begin
          if (cnt_q == CNT_LAST) begin
            state_d = PS_NORMAL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = PS_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_DESEL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R9: counter never runs past the window
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R8: supply returning always enters recovery
  a_r8_enter_recover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_ok_i) |=> state_q == PS_RECOVER);
  // R6: low supply above switchover means deselected
  a_r6_desel_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok_i && sup_sw_i) |=> state_q == PS_DESEL);
  // R7: both flags low means battery backup
  a_r7_battery_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok_i && !sup_sw_i) |=> state_q == PS_BATTERY);
endmodule

// File: rtl/pgs_decode.sv
`timescale 1ns/1ps
module pgs_decode (
  input  logic allow_i,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic wr_en_o,
  output logic rd_en_o
);
  logic sel;
  assign sel     = allow_i && !ce_n_i;
  assign wr_en_o = sel && !we_n_i;
  assign rd_en_o = sel && we_n_i && !oe_n_i;
endmodule

// File: rtl/pgs_array.sv
`timescale 1ns/1ps
module pgs_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  // R7: contents frozen while in battery backup
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !wr_en_i);
endmodule

// File: rtl/pgs_top.sv
`timescale 1ns/1ps
module pgs_top
  import pgs_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int RECOV_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_ok,
  input  logic              sup_sw,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic [1:0]        status
);
  pwr_state_e        pstate;
  logic              allow, wr_en, rd_en;
  logic [DATA_W-1:0] raw;

  pgs_supervisor #(.RECOV_CYC(RECOV_CYC)) u_sup (
    .clk(clk), .rst_n(rst_n), .sup_ok_i(sup_ok), .sup_sw_i(sup_sw),
    .state_o(pstate)
  );

  assign allow = (pstate == PS_NORMAL) && sup_ok;

  pgs_decode u_dec (
    .allow_i(allow), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  pgs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .hold_i(pstate == PS_BATTERY),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wr_data), .rdata_o(raw)
  );

  assign rd_oe   = rd_en;
  assign rd_data = rd_en ? raw : '0;
  assign status  = pstate;

  // R2: deselected chip neither drives nor writes
  a_r2_ce_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!rd_oe && !wr_en));
  // R6: out-of-tolerance supply blocks everything in the same cycle
  a_r6_low_supply_block: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |-> (!rd_oe && !wr_en));
  // R3: a write cycle never drives the output
  a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_oe);
  // R8: nothing is honoured outside normal state
  a_r8_gate_outside_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) |-> (!rd_oe && !wr_en));
  // R4: undriven output reads as zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
endmodule

// File: tb/tb_pgs_top.sv
`timescale 1ns/1ps
module tb_pgs_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int RC = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok = 1'b1, sup_sw = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_oe;
  logic [1:0] status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pgs_top #(.ADDR_W(AW), .DATA_W(DW), .RECOV_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .sup_sw(sup_sw),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_oe(rd_oe), .status(status)
  );

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37) + (a >> 4) + seed);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a); wr_data = d;
    step();
    idle();
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
    #1;
    chk(rd_oe === 1'b1 && rd_data === exp, req, int'(rd_data), int'(exp));
    idle();
  endtask

  task automatic count_recover(input string req);
    int n = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      if (status == 2'd2) n++;
      else begin
        idle();
        break;
      end
    end
    chk(n == RC && status == 2'd0, req, n, RC);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    chk(status == 2'd1 && rd_oe == 1'b0, "R10 reset state", int'(status), 1);
    @(negedge clk);
    rst_n = 1'b1;
    count_recover("R10 recovery after reset");

    // R1 / R11: back-to-back writes over every address, then read all
    for (int a = 0; a < DEPTH; a++) begin
      ce_n = 1'b0; we_n = 1'b0; oe_n = a[0]; addr = AW'(a); wr_data = pat(a, 0);
      step();
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      rd_chk(a, pat(a, 0), (a % 2 == 0) ? "R1 sweep" : "R11 back-to-back");
      step();
    end

    // R3: write with oe_n low stores, no drive
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = AW'(5); wr_data = 8'hC3;
    #1;
    chk(rd_oe == 1'b0, "R3 no drive on write", int'(rd_oe), 0);
    step(); idle();
    rd_chk(5, 8'hC3, "R3 write with oe low");

    // R2: ce_n high, every we/oe combination
    for (int m = 0; m < 4; m++) begin
      ce_n = 1'b1; we_n = m[0]; oe_n = m[1]; addr = AW'(9); wr_data = 8'h11;
      #1;
      chk(rd_oe == 1'b0 && rd_data == 8'h00, "R2 deselect quiet", int'(rd_oe), 0);
      step();
    end
    rd_chk(9, pat(9, 0), "R2 no write when deselected");

    // R5: both enables high
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = AW'(12); wr_data = 8'hEE;
    #1;
    chk(rd_oe == 1'b0 && rd_data == 8'h00, "R5 idle select", int'(rd_oe), 0);
    step();
    rd_chk(12, pat(12, 0), "R5 no write");

    // R6: low supply, above switchover
    sup_ok = 1'b0;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(20);
    #1;
    chk(rd_oe == 1'b0, "R6 immediate block", int'(rd_oe), 0);
    we_n = 1'b0; wr_data = 8'h77;
    step();
    chk(status == 2'd1, "R6 deselected status", int'(status), 1);
    step();

    // R7: battery backup
    sup_sw = 1'b0; addr = AW'(21); wr_data = 8'h99;
    step();
    chk(status == 2'd3, "R7 battery status", int'(status), 3);
    for (int i = 0; i < 4; i++) step();
    sup_sw = 1'b1;
    step();
    chk(status == 2'd1, "R6 back to deselected", int'(status), 1);

    // R8: recovery with writes attempted throughout
    ce_n = 1'b0; we_n = 1'b0; addr = AW'(22); wr_data = 8'h55;
    sup_ok = 1'b1;
    count_recover("R8 recovery length");
    rd_chk(20, pat(20, 0), "R6 contents unchanged");
    rd_chk(21, pat(21, 0), "R7 contents kept");
    rd_chk(22, pat(22, 0), "R8 ignored during recovery");

    // R9: dip during recovery restarts the window
    sup_ok = 1'b0;
    step();
    sup_ok = 1'b1;
    for (int i = 0; i < 5; i++) step();
    chk(status == 2'd2, "R9 mid recovery", int'(status), 2);
    sup_ok = 1'b0;
    step();
    chk(status == 2'd1, "R9 dip", int'(status), 1);
    sup_ok = 1'b1;
    count_recover("R9 full restart");

    // R10: reset keeps memory
    wr(30, 8'hA5);
    rst_n = 1'b0;
    #1;
    chk(status == 2'd1, "R10 reset status", int'(status), 1);
    step();
    rst_n = 1'b1;
    count_recover("R10 recovery again");
    rd_chk(30, 8'hA5, "R10 contents survive reset");
    rd_chk(31, pat(31, 0), "R10 neighbour survives");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule